// File: doc/BRIEF.md
# Three-Parallel Fast FIR Filter

This block is a block-processing FIR filter that takes three consecutive input samples on every accepted clock and returns three consecutive filtered samples. The N-tap impulse response is split into three phase sub-responses. The nine cross products that a plain polyphase form needs are replaced by six shared sub-filters, each N/3 taps long. They are fed by a small input pre-add network. A subtractive post-add network recombines their outputs and holds two terms for one block.

The coefficients are fixed at elaboration through a packed parameter. The sub-filter coefficient sets (single phases and phase sums) are derived from that parameter when the block is built. Every internal sum is wide enough to be exact, and the outputs are never rounded. A valid strobe qualifies each input block. The filter state, including the one-block delays, advances only on accepted blocks. A stream with gaps therefore filters the same as a dense one.

Top module: `pfir3_fast_fir`

## Requirements
- R1: For accepted blocks n = 0,1,2,... with `x_p0`,`x_p1`,`x_p2` carrying x[3n], x[3n+1], x[3n+2], the clock edge that accepts block n loads `y_p0`,`y_p1`,`y_p2` with y[3n], y[3n+1], y[3n+2], where y[m] = sum over k of h[k]·x[m−k]. `out_valid` is high for exactly the cycle after that edge.
- R2: A cycle with `in_valid` low changes no filter state. The outputs keep their previous values, `out_valid` is low the following cycle, and later results equal those of the same blocks sent without gaps.
- R3: After reset, `out_valid` is 0, all outputs are 0, and every sample before the first accepted block counts as zero. This holds for a reset applied in the middle of a stream as well.
- R4: `COEFS` holds h[k] in bits [k·CW +: CW], two's complement. h[0] weights the newest sample. A unit impulse in `x_p0` of the first block returns h[3j], h[3j+1], h[3j+2] on block j.
- R5: The outputs are signed and DW+CW+ceil(log2 N) bits wide, and they are exact for any input and coefficient values, including full-scale values of either sign.
- R6: Within a block, `x_p0` is the oldest sample and `x_p2` the newest. A unit impulse in `x_p1` or `x_p2` returns the impulse response shifted by one or two output positions across the three output lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block is accepted on this edge |
| x_p0 | input | DW | Oldest sample of the block, signed |
| x_p1 | input | DW | Middle sample of the block, signed |
| x_p2 | input | DW | Newest sample of the block, signed |
| out_valid | output | 1 | Outputs hold a fresh block |
| y_p0 | output | DW+CW+clog2(NTAPS) | Output for phase 0, signed |
| y_p1 | output | DW+CW+clog2(NTAPS) | Output for phase 1, signed |
| y_p2 | output | DW+CW+clog2(NTAPS) | Output for phase 2, signed |

## Verification
The assertions check four properties on every cycle. The three pre-adders agree with each other. Each recombined output fits the output width, which means the guard bits only repeat the sign. The held delay terms and the outputs stay frozen across idle cycles. Reset leaves the outputs idle. The assertions cannot show that the six sub-filters and the post-add network together produce the right convolution. Only the bench scenarios show that: they compare each output against a scalar tap-by-tap model under table stimulus, impulses in each phase, random data with gaps, a mid-stream reset and full-scale inputs.

// File: rtl/pfir3_pkg.sv
`timescale 1ns/1ps
package pfir3_pkg;
   localparam int NPH  = 3;
   localparam int NSUB = 6;

   // sub-filter slots; order is shared by pre-add outputs and post-add inputs
   typedef enum logic [2:0] {
      SF_P0   = 3'd0,
      SF_P1   = 3'd1,
      SF_P2   = 3'd2,
      SF_P01  = 3'd3,
      SF_P12  = 3'd4,
      SF_P012 = 3'd5
   } subf_e;

   // which coefficient phases are summed into each sub-filter
   function automatic logic [NPH-1:0] phase_mask(subf_e sf);
      case (sf)
         SF_P0:   return 3'b001;
         SF_P1:   return 3'b010;
         SF_P2:   return 3'b100;
         SF_P01:  return 3'b011;
         SF_P12:  return 3'b110;
         default: return 3'b111;
      endcase
   endfunction
endpackage

// File: rtl/pfir3_preadd.sv
`timescale 1ns/1ps
module pfir3_preadd
   import pfir3_pkg::*;
#(
   parameter int DW = 16,
   parameter int XW = DW + 2
) (
   input  logic signed [DW-1:0] x0,
   input  logic signed [DW-1:0] x1,
   input  logic signed [DW-1:0] x2,
   output logic signed [XW-1:0] sx [NSUB]
);
   logic signed [XW-1:0] e0, e1, e2;

   assign e0 = XW'(x0);
   assign e1 = XW'(x1);
   assign e2 = XW'(x2);

   assign sx[SF_P0]   = e0;
   assign sx[SF_P1]   = e1;
   assign sx[SF_P2]   = e2;
   assign sx[SF_P01]  = e0 + e1;
   assign sx[SF_P12]  = e1 + e2;
   assign sx[SF_P012] = sx[SF_P01] + e2;

   // R1
   always_comb begin
      preadd_sum_chk: assert (sx[SF_P012] == e0 + sx[SF_P12]);
   end
endmodule

// File: rtl/pfir3_subfilter.sv
`timescale 1ns/1ps
module pfir3_subfilter #(
   parameter int TAPS = 8,
   parameter int XW   = 18,
   parameter int KW   = 18,
   parameter int AW   = 40,
   parameter logic [TAPS*KW-1:0] COEF = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [XW-1:0] x_in,
   output logic signed [AW-1:0] f_out
);
   logic signed [XW-1:0] tap [TAPS];
   logic signed [AW-1:0] cw  [TAPS];
   logic signed [AW-1:0] acc;

   assign tap[0] = x_in;

   for (genvar k = 0; k < TAPS; k++) begin : g_coef
      assign cw[k] = AW'($signed(COEF[k*KW +: KW]));
   end

   if (TAPS > 1) begin : g_hist
      logic signed [XW-1:0] hist [TAPS-1];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < TAPS-1; i++) hist[i] <= '0;
         end else if (en) begin
            hist[0] <= x_in;
            for (int i = 1; i < TAPS-1; i++) hist[i] <= hist[i-1];
         end
      end
      for (genvar k = 1; k < TAPS; k++) begin : g_tap
         assign tap[k] = hist[k-1];
      end
   end

   always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS; k++) acc = acc + AW'(tap[k]) * cw[k];
   end

   assign f_out = acc;
endmodule

// File: rtl/pfir3_postadd.sv
`timescale 1ns/1ps
module pfir3_postadd
   import pfir3_pkg::*;
#(
   parameter int AW = 40,
   parameter int OW = 37
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [AW-1:0] f [NSUB],
   output logic                 out_valid,
   output logic signed [OW-1:0] y0,
   output logic signed [OW-1:0] y1,
   output logic signed [OW-1:0] y2
);
   logic signed [AW-1:0] t_01, t_12, a_0, s0, s1, s2;
   logic signed [AW-1:0] d_p2, d_12;

   // seven post adders
   assign t_01 = f[SF_P01] - f[SF_P1];
   assign t_12 = f[SF_P12] - f[SF_P1];
   assign a_0  = f[SF_P0]  - d_p2;
   assign s0   = a_0 + d_12;
   assign s1   = t_01 - a_0;
   assign s2   = f[SF_P012] - t_01 - t_12;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_p2      <= '0;
         d_12      <= '0;
         y0        <= '0;
         y1        <= '0;
         y2        <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            d_p2 <= f[SF_P2];
            d_12 <= t_12;
            y0   <= s0[OW-1:0];
            y1   <= s1[OW-1:0];
            y2   <= s2[OW-1:0];
         end
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> ((s0[AW-1:OW-1] == '0) || (s0[AW-1:OW-1] == '1)) &&
                   ((s1[AW-1:OW-1] == '0) || (s1[AW-1:OW-1] == '1)) &&
                   ((s2[AW-1:OW-1] == '0) || (s2[AW-1:OW-1] == '1)));

   // R2
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(y0) && $stable(y1) && $stable(y2) && !out_valid);

   // R2
   delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(d_p2) && $stable(d_12));
endmodule

// File: rtl/pfir3_fast_fir.sv
`timescale 1ns/1ps
module pfir3_fast_fir
   import pfir3_pkg::*;
#(
   parameter int NTAPS = 24,
   parameter int DW    = 16,
   parameter int CW    = 16,
   parameter logic [NTAPS*CW-1:0] COEFS = {
      -16'sd120,  -16'sd310,  -16'sd280,  16'sd240,   16'sd900,   16'sd1100,
       16'sd120,  -16'sd1800, -16'sd3200, -16'sd1500, 16'sd4200,  16'sd12000,
       16'sd12000, 16'sd4200, -16'sd1500, -16'sd3200, -16'sd1800, 16'sd120,
       16'sd1100,  16'sd900,   16'sd240,  -16'sd280,  -16'sd310,  -16'sd120}
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      in_valid,
   input  logic signed [DW-1:0]                      x_p0,
   input  logic signed [DW-1:0]                      x_p1,
   input  logic signed [DW-1:0]                      x_p2,
   output logic                                      out_valid,
   output logic signed [DW+CW+$clog2(NTAPS)-1:0]     y_p0,
   output logic signed [DW+CW+$clog2(NTAPS)-1:0]     y_p1,
   output logic signed [DW+CW+$clog2(NTAPS)-1:0]     y_p2
);
   localparam int STAGE_TAPS = NTAPS / NPH;
   localparam int XW = DW + 2;
   localparam int KW = CW + 2;
   localparam int AW = DW + CW + 5 + $clog2(STAGE_TAPS);
   localparam int OW = DW + CW + $clog2(NTAPS);

   if (NTAPS % NPH != 0 || NTAPS < NPH) begin : g_bad_taps
      $error("NTAPS must be a positive multiple of three");
   end
   if (DW < 2 || CW < 2) begin : g_bad_width
      $error("DW and CW must be at least 2");
   end

   // coefficient set of one sub-filter: sum of the selected phases per tap
   function automatic logic [STAGE_TAPS*KW-1:0] sub_coefs(logic [NPH-1:0] m);
      logic [STAGE_TAPS*KW-1:0] v;
      logic signed [KW-1:0]     acc;
      logic signed [CW-1:0]     c;
      v = '0;
      for (int k = 0; k < STAGE_TAPS; k++) begin
         acc = '0;
         for (int p = 0; p < NPH; p++) begin
            if (m[p]) begin
               c   = COEFS[(NPH*k+p)*CW +: CW];
               acc = acc + KW'(c);
            end
         end
         v[k*KW +: KW] = acc;
      end
      return v;
   endfunction

   logic signed [XW-1:0] sx [NSUB];
   logic signed [AW-1:0] fo [NSUB];

   pfir3_preadd #(.DW(DW), .XW(XW)) u_pre (
      .x0(x_p0), .x1(x_p1), .x2(x_p2), .sx(sx)
   );

   for (genvar g = 0; g < NSUB; g++) begin : g_sub
      pfir3_subfilter #(
         .TAPS(STAGE_TAPS), .XW(XW), .KW(KW), .AW(AW),
         .COEF(sub_coefs(phase_mask(subf_e'(g))))
      ) u_sf (
         .clk(clk), .rst_n(rst_n), .en(in_valid),
         .x_in(sx[g]), .f_out(fo[g])
      );
   end

   pfir3_postadd #(.AW(AW), .OW(OW)) u_post (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .f(fo),
      .out_valid(out_valid), .y0(y_p0), .y1(y_p1), .y2(y_p2)
   );

   // R3
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid && y_p0 == '0 && y_p1 == '0 && y_p2 == '0);
endmodule

// File: tb/pfir3_fast_fir_tb.sv
`timescale 1ns/1ps
module pfir3_fast_fir_tb;
   localparam int NT = 24;
   localparam int DW = 16;
   localparam int CW = 16;
   localparam int OW = DW + CW + $clog2(NT);

   localparam int H [NT] = '{
      -32768, 32767, 20000, -15000, 1, -1, 30000, -25000,
      12345, -4321, 777, 32000, -31000, 5, 9999, -8888,
      16384, -16384, 250, -7, 28000, -29000, 3, 100};

   function automatic logic [NT*CW-1:0] pack_h();
      logic [NT*CW-1:0] v;
      for (int k = 0; k < NT; k++) v[k*CW +: CW] = CW'(H[k]);
      return v;
   endfunction

   // valid, x0, x1, x2
   localparam int STIM [12][4] = '{
      '{1, 100, -200, 300}, '{1, 0, 0, 0}, '{0, 999, 999, 999},
      '{1, -32768, 32767, -1}, '{1, 5, 6, 7}, '{0, -5, -6, -7},
      '{0, 1, 1, 1}, '{1, 1000, -1000, 2000}, '{1, 32767, 32767, 32767},
      '{1, -300, 0, 42}, '{0, 0, 0, 0}, '{1, 11, -22, 33}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] x_p0 = '0, x_p1 = '0, x_p2 = '0;
   logic out_valid;
   logic signed [OW-1:0] y_p0, y_p1, y_p2;

   always #2.5 clk = ~clk;

   pfir3_fast_fir #(.NTAPS(NT), .DW(DW), .CW(CW), .COEFS(pack_h())) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .x_p0(x_p0), .x_p1(x_p1), .x_p2(x_p2),
      .out_valid(out_valid), .y_p0(y_p0), .y_p1(y_p1), .y_p2(y_p2));

   int n_chk = 0, n_err = 0;
   int samp [2048];
   int ns = 0;
   bit pend_v = 0;
   string pend_tag = "R3";
   string tag = "R1";
   longint e0 = 0, e1 = 0, e2 = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic longint refy(input int m);
      longint s = 0;
      for (int k = 0; k < NT; k++)
         if (m - k >= 0) s += longint'(H[k]) * longint'(samp[m-k]);
      return s;
   endfunction

   function automatic int rnd16();
      logic signed [15:0] r;
      r = 16'($urandom);
      return int'(r);
   endfunction

   // called at a falling edge: check the result of the previous block, drive the next
   task automatic step(input bit v, input int a, input int b, input int c);
      string rq;
      rq = pend_v ? pend_tag : (pend_tag == "R3" ? "R3" : "R2");
      chk(out_valid == pend_v, rq, "out_valid", longint'(out_valid), longint'(pend_v));
      chk(longint'(y_p0) == e0, rq, "y_p0", longint'(y_p0), e0);
      chk(longint'(y_p1) == e1, rq, "y_p1", longint'(y_p1), e1);
      chk(longint'(y_p2) == e2, rq, "y_p2", longint'(y_p2), e2);
      in_valid = v;
      x_p0 = DW'(a);
      x_p1 = DW'(b);
      x_p2 = DW'(c);
      if (v) begin
         samp[ns] = a; samp[ns+1] = b; samp[ns+2] = c;
         e0 = refy(ns); e1 = refy(ns+1); e2 = refy(ns+2);
         ns += 3;
      end
      pend_v = v;
      pend_tag = v ? tag : (pend_tag == "R3" ? "R3" : "R2");
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      ns = 0; pend_v = 0; pend_tag = "R3";
      e0 = 0; e1 = 0; e2 = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      do_reset();
      // R3: idle outputs straight after reset
      chk(out_valid == 1'b0, "R3", "out_valid after reset", longint'(out_valid), 0);
      chk(y_p0 == '0 && y_p1 == '0 && y_p2 == '0, "R3", "outputs after reset",
          longint'(y_p0), 0);

      // R1 / R2: table walk, gaps in the table exercise the hold behaviour
      tag = "R1";
      for (int i = 0; i < 12; i++) step(STIM[i][0] != 0, STIM[i][1], STIM[i][2], STIM[i][3]);
      for (int i = 0; i < 9; i++) step(1, 0, 0, 0);

      // R4: impulse in the oldest lane reproduces the taps in order
      do_reset();
      tag = "R4";
      step(1, 1, 0, 0);
      for (int i = 0; i < 9; i++) step(1, 0, 0, 0);

      // R6: impulse in the middle lane, then in the newest lane
      do_reset();
      tag = "R6";
      step(1, 0, 1, 0);
      for (int i = 0; i < 9; i++) step(1, 0, 0, 0);
      do_reset();
      step(1, 0, 0, -1);
      for (int i = 0; i < 9; i++) step(1, 0, 0, 0);

      // R1 / R2: random data with random idle cycles
      do_reset();
      tag = "R1";
      for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, rnd16(), rnd16(), rnd16());

      // R3: reset in mid-stream clears history, then an impulse shows the bare taps
      tag = "R3";
      do_reset();
      step(1, 1, 0, 0);
      for (int i = 0; i < 8; i++) step(1, 0, 0, 0);

      // R5: full-scale inputs aligned with coefficient signs, both polarities
      for (int pol = 0; pol < 2; pol++) begin
         do_reset();
         tag = "R5";
         for (int blk = 0; blk < 12; blk++) begin
            int v3 [3];
            for (int p = 0; p < 3; p++) begin
               int j;
               j = 26 - (3*blk + p);
               if (j < 0 || j >= NT) v3[p] = 0;
               else v3[p] = ((H[j] >= 0) ^ (pol != 0)) ? 32767 : -32768;
            end
            step(1, v3[0], v3[1], v3[2]);
         end
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule